// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer/counter. It runs a free-running up counter. An external trigger input, once synchronised, can copy the counter into either of two capture registers. The edge that loads each register is chosen separately. The trigger can also return the counter to zero. A third register sets a compare threshold. Capture, trigger, compare and wrap events set sticky status flags, and each flag can be masked onto a level interrupt output.

Software drives the channel through a small register port with eight word addresses. It picks the edges and options in the control word, starts the counter with a command write, and reads the status word to collect and clear events. An option halts counting once the second capture register has been loaded. A waveform-mode bit takes the channel out of capture operation, and only capture operation is implemented.

Top module: `tcc_channel`

## Requirements
- R1: The capture registers A (address 3) and B (address 4) and the threshold (address 5) are written through the port and read back unchanged. The control word is at address 0, the interrupt enables at address 7 (bits 4:0) and the counter value at address 2, which is read-only.
- R2: An edge-select field codes 0 as none, 1 as rising, 2 as falling and 3 as both. When the trigger edge matches the A field (control bits 2:1), the counter value held in that cycle is copied into register A. On a clash, the capture takes priority over a software write.
- R3: Register B is loaded the same way, using its own field (control bits 4:3). When both fields select the same edge, A and B capture the same value.
- R4: A load of A sets status bit 0 and a load of B sets status bit 1.
- R5: When the trigger edge matches the restart field (control bits 6:5), the counter goes to zero and status bit 2 is set.
- R6: When the counter steps into the value held in the threshold register, status bit 3 is set.
- R7: The counter wraps from its maximum value to zero and sets status bit 4 on the clock of the wrap.
- R8: With control bit 7 set, the counter stops after a load of B. Writing 1 to bit 0 of address 1 sets the counter to zero and starts it. Reading address 1 returns the running bit. After reset the counter is stopped at zero.
- R9: While control bit 0 (waveform mode) is set, trigger edges load neither capture register and do not restart the counter.
- R10: Status flags (address 6) are sticky. A read with rd_en high clears them. An event that arrives in the same cycle as the clearing read remains set.
- R11: irq is high exactly when some status bit and its enable bit are both set.
- R12: A trigger change takes effect at the (SYNC_STAGES+1)-th rising clock edge after the change.
- R13: The counter advances only while clk_en is high.
- R14: Reset clears all registers, flags and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Count enable |
| trig_in | input | 1 | Asynchronous trigger input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; clears status when addr is 6 |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with an 8-bit counter, so a wrap occurs after only 256 counting cycles. At that width the overflow flag and a clearing status read in the same cycle as a flag event can be reached within a short run. It also uses a three-stage synchroniser, which exercises the generated chain beyond its default depth and checks the trigger latency at a non-default value.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_CMD  = 3'd1;
   localparam logic [2:0] A_CNT  = 3'd2;
   localparam logic [2:0] A_CAPA = 3'd3;
   localparam logic [2:0] A_CAPB = 3'd4;
   localparam logic [2:0] A_THR  = 3'd5;
   localparam logic [2:0] A_STAT = 3'd6;
   localparam logic [2:0] A_IEN  = 3'd7;

   localparam int NFLAG = 5;
   localparam int F_CAPA = 0;
   localparam int F_CAPB = 1;
   localparam int F_TRG  = 2;
   localparam int F_CMP  = 3;
   localparam int F_OVF  = 4;

   typedef struct packed {
      logic       stop_b;
      logic [1:0] rst_edge;
      logic [1:0] b_edge;
      logic [1:0] a_edge;
      logic       wave;
   } ctrl_t;

   function automatic logic edge_hit(input logic [1:0] sel, input logic r, input logic f);
      return (sel[0] & r) | (sel[1] & f);
   endfunction
endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tcc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;

   assert_rise_single_R12: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
   assert_fall_single_R12: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clk_en,
   input  logic         start,
   input  logic         trg_clr,
   input  logic         halt,
   input  logic [W-1:0] thr,
   output logic [W-1:0] cv,
   output logic         run,
   output logic         wrap,
   output logic         cmp_hit
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   logic         step;
   logic [W-1:0] cv_inc;

   assign step    = run & clk_en & ~start & ~trg_clr;
   assign cv_inc  = cv + 1'b1;
   assign wrap    = step & (cv == MAXV);
   assign cmp_hit = step & (cv_inc == thr);

   always_ff @(posedge clk) begin
      if (rst) begin
         cv  <= '0;
         run <= 1'b0;
      end else begin
         if (start || trg_clr) cv <= '0;
         else if (step)        cv <= cv_inc;
         if (start)     run <= 1'b1;
         else if (halt) run <= 1'b0;
      end
   end

   assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst) wrap |=> (cv == '0));
   assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
      (!clk_en && !start && !trg_clr) |=> $stable(cv));
   assert_start_R8: assert property (@(posedge clk) disable iff (rst) start |=> (cv == '0 && run));
endmodule

// File: rtl/tcc_status.sv
module tcc_status #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flags
);
   always_ff @(posedge clk) begin
      if (rst)      flags <= '0;
      else if (clr) flags <= set;
      else          flags <= flags | set;
   end

   assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      !clr |=> ((flags & $past(flags)) == $past(flags)));
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (|set) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clk_en,
   input  logic             trig_in,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq
);
   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_w
         $error("tcc_channel: CNT_W must lie in 8..32");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [NFLAG-1:0] ien_q;
   logic [CNT_W-1:0] ra_q, rb_q, rc_q, cv;
   logic             run, wrap, cmp_hit;
   logic             t_rise, t_fall;
   logic             cap_a, cap_b, trg, start;
   logic [NFLAG-1:0] set, flags;

   tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(trig_in), .rise(t_rise), .fall(t_fall));

   assign cap_a = ~ctrl_q.wave & edge_hit(ctrl_q.a_edge, t_rise, t_fall);
   assign cap_b = ~ctrl_q.wave & edge_hit(ctrl_q.b_edge, t_rise, t_fall);
   assign trg   = ~ctrl_q.wave & edge_hit(ctrl_q.rst_edge, t_rise, t_fall);
   assign start = wr_en & (addr == A_CMD) & wdata[0];

   tcc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .trg_clr(trg),
      .halt(cap_b & ctrl_q.stop_b), .thr(rc_q), .cv(cv), .run(run),
      .wrap(wrap), .cmp_hit(cmp_hit));

   always_comb begin
      set         = '0;
      set[F_CAPA] = cap_a;
      set[F_CAPB] = cap_b;
      set[F_TRG]  = trg;
      set[F_CMP]  = cmp_hit;
      set[F_OVF]  = wrap;
   end

   tcc_status #(.N(NFLAG)) u_stat (
      .clk(clk), .rst(rst), .set(set), .clr(rd_en & (addr == A_STAT)), .flags(flags));

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         ien_q  <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         rc_q   <= '0;
      end else begin
         if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_en && addr == A_IEN)  ien_q  <= wdata[NFLAG-1:0];
         if (wr_en && addr == A_THR)  rc_q   <= wdata;
         if (cap_a)                            ra_q <= cv;
         else if (wr_en && addr == A_CAPA)     ra_q <= wdata;
         if (cap_b)                            rb_q <= cv;
         else if (wr_en && addr == A_CAPB)     rb_q <= wdata;
      end
   end

   always_comb begin
      unique case (addr)
         A_CTRL:  rdata = CNT_W'(ctrl_q);
         A_CMD:   rdata = CNT_W'(run);
         A_CNT:   rdata = cv;
         A_CAPA:  rdata = ra_q;
         A_CAPB:  rdata = rb_q;
         A_THR:   rdata = rc_q;
         A_STAT:  rdata = CNT_W'(flags);
         default: rdata = CNT_W'(ien_q);
      endcase
   end

   assign irq = |(flags & ien_q);

   assert_capture_a_R2: assert property (@(posedge clk) disable iff (rst) cap_a |=> (ra_q == $past(cv)));
   assert_capture_b_R3: assert property (@(posedge clk) disable iff (rst) cap_b |=> (rb_q == $past(cv)));
   assert_wave_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q.wave && !(wr_en && addr == A_CAPA)) |=> $stable(ra_q));
   assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst) (ien_q == '0) |-> !irq);
endmodule

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
   localparam int W = 8;
   localparam int S = 3;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 0, rst = 1, clk_en = 1, trig = 0, wr_en = 0, rd_en = 0;
   logic [2:0]   addr = 0;
   logic [W-1:0] wdata = 0;
   logic [W-1:0] rdata;
   logic         irq;

   always #10 clk = ~clk;

   tcc_channel #(.CNT_W(W), .SYNC_STAGES(S)) dut (
      .clk(clk), .rst(rst), .clk_en(clk_en), .trig_in(trig), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   int vecs = 0, errs = 0, cycles = 0;
   string req = "R14";

   // behavioural reference
   int m_cv, m_run, m_ra, m_rb, m_rc, m_ctrl, m_ien, m_st;
   bit m_sync[S];
   bit m_prev;

   function automatic bit hit(int sel, bit r, bit f);
      return ((sel == 1 || sel == 3) && r) || ((sel == 2 || sel == 3) && f);
   endfunction

   always @(posedge clk) begin : model
      bit r, f, ca, cb, tg, strt, step;
      int setv, nxt;
      if (rst) begin
         m_cv = 0; m_run = 0; m_ra = 0; m_rb = 0; m_rc = 0;
         m_ctrl = 0; m_ien = 0; m_st = 0; m_prev = 0;
         for (int i = 0; i < S; i++) m_sync[i] = 0;
      end else begin
         r = m_sync[S-1] && !m_prev;
         f = !m_sync[S-1] && m_prev;
         ca = !m_ctrl[0] && hit((m_ctrl >> 1) & 3, r, f);
         cb = !m_ctrl[0] && hit((m_ctrl >> 3) & 3, r, f);
         tg = !m_ctrl[0] && hit((m_ctrl >> 5) & 3, r, f);
         strt = wr_en && addr == 1 && wdata[0];
         step = m_run != 0 && clk_en && !strt && !tg;
         nxt = (m_cv + 1) % (MAXV + 1);
         setv = 0;
         if (ca) setv |= 1;
         if (cb) setv |= 2;
         if (tg) setv |= 4;
         if (step && nxt == m_rc) setv |= 8;
         if (step && m_cv == MAXV) setv |= 16;
         if (rd_en && addr == 6) m_st = setv; else m_st |= setv;
         if (ca) m_ra = m_cv; else if (wr_en && addr == 3) m_ra = int'(wdata);
         if (cb) m_rb = m_cv; else if (wr_en && addr == 4) m_rb = int'(wdata);
         if (wr_en && addr == 5) m_rc = int'(wdata);
         if (wr_en && addr == 0) m_ctrl = int'(wdata);
         if (wr_en && addr == 7) m_ien = int'(wdata) & 31;
         if (strt) m_run = 1; else if (cb && m_ctrl[7]) m_run = 0;
         if (strt || tg) m_cv = 0; else if (step) m_cv = nxt;
         m_prev = m_sync[S-1];
         for (int i = S - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
         m_sync[0] = trig;
      end
   end

   function automatic int exp_rd(int a);
      case (a)
         0: return m_ctrl;
         1: return m_run;
         2: return m_cv;
         3: return m_ra;
         4: return m_rb;
         5: return m_rc;
         6: return m_st;
         default: return m_ien;
      endcase
   endfunction

   task automatic tick();
      int e;
      bit ei;
      @(posedge clk);
      #5;
      vecs++;
      e = exp_rd(int'(addr));
      ei = (m_st & m_ien) != 0;
      if (int'(rdata) != e || irq != ei) begin
         errs++;
         $display("FAIL %s addr=%0d rdata=%0h expected=%0h irq=%0b expected=%0b",
                  req, addr, rdata, e, irq, ei);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         addr = 3'(i);
         tick();
      end
   endtask

   task automatic wr(int a, int d);
      wr_en = 1; addr = 3'(a); wdata = W'(d);
      tick();
      wr_en = 0;
   endtask

   task automatic rd(int a, bit clr);
      addr = 3'(a); rd_en = clr;
      tick();
      rd_en = 0;
   endtask

   task automatic pulse(int hi, int lo);
      trig = 1; idle(hi);
      trig = 0; idle(lo);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 40000) begin
         errs++;
         $display("FAIL R14 watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      // R14: reset state
      req = "R14";
      tick(); tick();
      rst = 0;
      idle(8);
      // R1: register access
      req = "R1";
      wr(3, 8'h5A); wr(4, 8'hA5); wr(5, 8'h33); wr(7, 5'h1F);
      wr(2, 8'h77);
      idle(8);
      // R2, R3, R4, R12: separate edges for A and B
      req = "R2";
      wr(0, 18);
      wr(1, 1);
      idle(20);
      rd(6, 1);
      pulse(7, 7);
      req = "R4"; idle(8); rd(6, 1);
      req = "R12"; trig = 1; for (int i = 0; i < 6; i++) rd(3, 0);
      trig = 0; for (int i = 0; i < 6; i++) rd(4, 0);
      // R3: same edge for both registers
      req = "R3";
      wr(0, 10);
      idle(5);
      pulse(5, 5);
      idle(8);
      // R5: restart edge
      req = "R5";
      wr(0, 32);
      idle(30);
      rd(6, 1);
      pulse(4, 4);
      idle(8);
      // R6: threshold
      req = "R6";
      wr(5, 60);
      rd(6, 1);
      wr(1, 1);
      for (int i = 0; i < 70; i++) rd(2, 0);
      idle(8);
      // R7: wrap
      req = "R7";
      for (int i = 0; i < 300; i++) rd(6, 0);
      idle(8);
      // R10: clearing reads across flag events
      req = "R10";
      wr(5, 3);
      for (int i = 0; i < 600; i++) rd(6, 1);
      // R11: mask
      req = "R11";
      wr(7, 0);
      idle(300);
      wr(7, 16);
      rd(6, 1);
      idle(300);
      wr(7, 31);
      // R8: stop after B, then restart
      req = "R8";
      wr(0, 136);
      wr(1, 1);
      idle(10);
      pulse(4, 4);
      for (int i = 0; i < 20; i++) rd(2, 0);
      rd(1, 0);
      wr(1, 1);
      for (int i = 0; i < 10; i++) rd(2, 0);
      // R9: waveform mode
      req = "R9";
      wr(0, 43);
      wr(3, 8'h11);
      rd(6, 1);
      pulse(5, 5);
      pulse(5, 5);
      idle(16);
      // R2: capture beats a software write in the same cycle
      req = "R2";
      wr(0, 6);
      trig = 1; idle(3);
      for (int i = 0; i < 6; i++) wr(3, 8'hC3);
      trig = 0; idle(8);
      // R13: count enable
      req = "R13";
      clk_en = 0;
      for (int i = 0; i < 20; i++) rd(2, 0);
      clk_en = 1;
      for (int i = 0; i < 20; i++) rd(2, 0);
      // R14: reset mid-run
      req = "R14";
      rst = 1; tick(); rst = 0;
      idle(16);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule